// File: doc/BRIEF.md
# Comparator Edge-Event Interrupt Controller

This block turns the raw digital outputs of three analog comparators into sticky interrupt flags and one combined interrupt request. Each comparator level first passes through a two-flop synchronizer. An optional per-channel inversion is then applied, and a 2-bit event code chooses which transitions of the adjusted level set that channel's flag: rising edges, falling edges, both, or none.

Software uses a small register port. Writes take effect on a clock edge and reads are combinational. Through this port software sets the per-channel configuration and the three levels of enable. It can also read the adjusted comparator levels, and it can write the flag vector directly, either to clear flags or to raise a simulated interrupt. A flag latches whatever the enables are. The request output is raised only when a channel has its flag set and its own enable set, and the peripheral enable and the global enable are also both set.

Top module: `cmp_evt_irq`

## Requirements
- R1: A raw input change applied before clock edge k sets a matching flag at edge k+2 (two synchronizer stages plus one edge-detect register), and not earlier.
- R2: Bit i of the status register (address 3, bits [2:0]) equals the synchronized input i XOR polarity bit i.
- R3: The event code of channel i is configuration register (address 0) bits [3i+2:3i+1]. Bit 3i is that channel's polarity. Code 00 never sets the flag, 01 sets it on a 0-to-1 change of the adjusted level, 10 on a 1-to-0 change, and 11 on any change.
- R4: A set flag stays set until software writes the flag register (address 1, bits [2:0]). Hardware never clears it.
- R5: A write to the flag register loads wr_data[2:0] into the flags, so a 1 sets a flag (simulated interrupt) and a 0 clears it.
- R6: irq_o is 1 exactly when some channel has both its flag and its enable set, the peripheral enable is set, and the global enable is set. The enable register is address 2: bits [2:0] are the channel enables, bit 3 is the peripheral enable, bit 4 is the global enable.
- R7: A qualifying event sets its flag even when any or all of the enables are clear.
- R8: When a hardware event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R9: A write that changes a polarity bit counts as a transition of the adjusted level, so a matching flag sets on the edge after that write.
- R10: Reset clears the flags, enables, polarity bits and event codes. Level changes seen in the first three cycles after reset release never set a flag.
- R11: Writes to address 3 have no effect. The configuration register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cmp_raw | input | 3 | Asynchronous comparator output levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Combinational read data |
| flag_o | output | 3 | Per-channel interrupt flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the reset release is synchronous and that the write strobe, address and data are stable around each rising clock edge. The comparator levels may change at any time, because they are sampled only through the synchronizer. The stimulus drives every input at the falling edge, so setup around the rising edge always holds. Random writes may collide with hardware events in any cycle, and that collision is exactly the case the set-wins rule covers.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_RISE = 2'b01,
    EV_FALL = 2'b10,
    EV_ANY  = 2'b11
  } evsel_e;

  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] A_CFG  = 2'd0;
  localparam logic [REG_AW-1:0] A_FLAG = 2'd1;
  localparam logic [REG_AW-1:0] A_EN   = 2'd2;
  localparam logic [REG_AW-1:0] A_STAT = 2'd3;

  localparam int unsigned CFG_BITS = 3;  // polarity + event code per channel
endpackage

// File: rtl/cmp_evt_sync.sv
module cmp_evt_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_evt_chan.sv
module cmp_evt_chan
  import cmp_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       pol,
  input  logic [1:0] evsel,
  input  logic       arm,
  input  logic       sw_wr,
  input  logic       sw_val,
  output logic       adj,
  output logic       flag
);
  logic prev_q;
  logic flag_q, flag_d;
  logic rise, fall, hit, hw_set;

  assign adj  = sync_in ^ pol;
  assign rise = adj & ~prev_q;
  assign fall = ~adj & prev_q;

  always_comb begin
    case (evsel_e'(evsel))
      EV_RISE: hit = rise;
      EV_FALL: hit = fall;
      EV_ANY:  hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end

  assign hw_set = arm & hit;

  // hardware set dominates a software clear
  always_comb begin
    flag_d = (sw_wr ? sw_val : flag_q) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= adj;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
  import cmp_evt_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [NCH-1:0]    status,
  input  logic [NCH-1:0]    flag,
  output logic [NCH-1:0]    pol,
  output logic [2*NCH-1:0]  evsel_flat,
  output logic [NCH-1:0]    ch_en,
  output logic              per_en,
  output logic              glb_en,
  output logic              flag_wr,
  output logic [DW-1:0]     rd_data
);
  localparam int unsigned CFG_W = CFG_BITS * NCH;
  localparam int unsigned EN_W  = NCH + 2;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [EN_W-1:0]  en_q, en_d;
  logic             cfg_we, en_we;

  assign cfg_we  = wr_en && (wr_addr == A_CFG);
  assign en_we   = wr_en && (wr_addr == A_EN);
  assign flag_wr = wr_en && (wr_addr == A_FLAG);

  always_comb begin
    cfg_d = cfg_we ? wr_data[CFG_W-1:0] : cfg_q;
    en_d  = en_we  ? wr_data[EN_W-1:0]  : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      en_q  <= en_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_field
    assign pol[i]            = cfg_q[CFG_BITS*i];
    assign evsel_flat[2*i+:2] = cfg_q[CFG_BITS*i+1 +: 2];
  end

  assign ch_en  = en_q[NCH-1:0];
  assign per_en = en_q[NCH];
  assign glb_en = en_q[NCH+1];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CFG:   rd_data[CFG_W-1:0] = cfg_q;
      A_FLAG:  rd_data[NCH-1:0]   = flag;
      A_EN:    rd_data[EN_W-1:0]  = en_q;
      default: rd_data[NCH-1:0]   = status;
    endcase
  end

  if (DW > CFG_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^wr_data[DW-1:CFG_W];
  end
endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
  import cmp_evt_pkg::*;
#(
  parameter int unsigned NCH         = 3,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cmp_raw,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NCH-1:0]    flag_o,
  output logic              irq_o
);
  localparam int unsigned WARM_N = SYNC_STAGES + 1;
  localparam int unsigned WW     = $clog2(WARM_N + 1);
  localparam logic [WW-1:0] WARM_DONE = WW'(WARM_N);

  logic [NCH-1:0]   cmp_sync, adj, flag, pol, ch_en;
  logic [2*NCH-1:0] evsel_flat;
  logic             per_en, glb_en, flag_wr, arm;
  logic [WW-1:0]    warm_q, warm_d;

  cmp_evt_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(cmp_sync)
  );

  cmp_evt_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .status(adj), .flag(flag),
    .pol(pol), .evsel_flat(evsel_flat), .ch_en(ch_en), .per_en(per_en),
    .glb_en(glb_en), .flag_wr(flag_wr), .rd_data(rd_data)
  );

  // edge detection stays off until the synchronizer holds real samples
  assign arm = (warm_q == WARM_DONE);

  always_comb begin
    warm_d = arm ? warm_q : warm_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= warm_d;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmp_evt_chan u_chan (
      .clk(clk), .rst_n(rst_n), .sync_in(cmp_sync[i]), .pol(pol[i]),
      .evsel(evsel_flat[2*i+:2]), .arm(arm), .sw_wr(flag_wr),
      .sw_val(wr_data[i]), .adj(adj[i]), .flag(flag[i])
    );
  end

  assign flag_o = flag;
  assign irq_o  = (|(flag & ch_en)) & per_en & glb_en;
endmodule

// File: rtl/cmp_evt_irq_chk.sv
module cmp_evt_irq_chk #(
  parameter int unsigned NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   flag,
  input logic             irq,
  input logic [NCH-1:0]   ch_en,
  input logic             per_en,
  input logic             glb_en,
  input logic [2*NCH-1:0] evsel_flat,
  input logic             flag_wr,
  input logic [NCH-1:0]   sw_val
);
  AST_IRQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (per_en && glb_en)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(flag & ch_en))); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_p
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !flag_wr) |=> flag[i]); // R4
    AST_SEL_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[i] && !flag_wr && evsel_flat[2*i+:2] == 2'b00) |=> !flag[i]); // R3
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && sw_val[i]) |=> flag[i]); // R5
  end
endmodule

bind cmp_evt_irq cmp_evt_irq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag(flag_o), .irq(irq_o), .ch_en(ch_en),
  .per_en(per_en), .glb_en(glb_en), .evsel_flat(evsel_flat),
  .flag_wr(flag_wr), .sw_val(wr_data[NCH-1:0])
);

// File: tb/cmp_evt_irq_tb.sv
`timescale 1ns/1ps
module cmp_evt_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmp_raw;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic [2:0]  flag_o;
  logic        irq_o;

  always #2.5 clk = ~clk;

  cmp_evt_irq u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .flag_o(flag_o), .irq_o(irq_o)
  );

  int total = 0, bad = 0;
  bit done = 0, mon_on = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  logic [2:0] m_s1, m_s2, m_prev, m_flag, m_adj, m_hit;
  logic [8:0] m_cfg;
  logic [4:0] m_en;
  int         m_warm;

  function automatic logic [2:0] pol_of(logic [8:0] c);
    for (int i = 0; i < 3; i++) pol_of[i] = c[3*i];
  endfunction

  function automatic logic [2:0] hit_of(logic [2:0] a, logic [2:0] p, logic [8:0] c);
    for (int i = 0; i < 3; i++) begin
      case (c[3*i+1 +: 2])
        2'b01:   hit_of[i] = a[i] & ~p[i];
        2'b10:   hit_of[i] = ~a[i] & p[i];
        2'b11:   hit_of[i] = a[i] ^ p[i];
        default: hit_of[i] = 1'b0;
      endcase
    end
  endfunction

  function automatic logic exp_irq();
    return (|(m_flag & m_en[2:0])) & m_en[3] & m_en[4];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0;
      m_cfg <= 0; m_en <= 0; m_warm <= 0;
    end else begin
      m_adj = m_s2 ^ pol_of(m_cfg);
      m_hit = (m_warm == 3) ? hit_of(m_adj, m_prev, m_cfg) : 3'b000;
      m_s1 <= cmp_raw;
      m_s2 <= m_s1;
      m_prev <= m_adj;
      if (m_warm < 3) m_warm <= m_warm + 1;
      if (wr_en && wr_addr == 2'd1) m_flag <= wr_data[2:0] | m_hit;
      else                          m_flag <= m_flag | m_hit;
      if (wr_en && wr_addr == 2'd0) m_cfg <= wr_data[8:0];
      if (wr_en && wr_addr == 2'd2) m_en  <= wr_data[4:0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_on && !done) begin
      chk("R3", "flags vs model", {29'd0, flag_o}, {29'd0, m_flag});
      chk("R6", "irq vs model", {31'd0, irq_o}, {31'd0, exp_irq()});
    end
  end

  // ---------------- helpers (called at a falling edge) ----------------
  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmp_raw = 3'b111; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    step(3);
    // R10 reset state
    chk("R10", "reset flags", {29'd0, flag_o}, 0);
    chk("R10", "reset irq", {31'd0, irq_o}, 0);
    rd(2'd0, r); chk("R10", "reset cfg", {16'd0, r}, 0);
    rd(2'd2, r); chk("R10", "reset enables", {16'd0, r}, 0);
    // release, and arm any-change on every channel during warm-up
    rst_n = 1'b1;
    mon_on = 1;
    wr(2'd0, 16'h01B6);
    step(6);
    chk("R10", "no flag from warm-up", {29'd0, flag_o}, 0);
    rd(2'd3, r); chk("R2", "status after warm-up", {16'd0, r}, 32'h7);

    wr(2'd0, 16'h0); wr(2'd1, 16'h0);
    cmp_raw = 3'b000; step(4);
    // R1 / R3 rising edge on channel 0
    wr(2'd0, 16'o002);
    cmp_raw[0] = 1'b1;
    step(2); chk("R1", "flag not before edge k+2", {29'd0, flag_o}, 0);
    step(1); chk("R1", "flag at edge k+2", {29'd0, flag_o}, 32'h1);
    chk("R7", "flag set with enables off, irq low", {31'd0, irq_o}, 0);
    // R3 falling edge ignored under rise code; R4 sticky
    cmp_raw[0] = 1'b0; step(4);
    chk("R4", "flag sticky", {29'd0, flag_o}, 32'h1);
    // R6 enable levels
    wr(2'd2, 16'b00001); chk("R6", "channel enable only", {31'd0, irq_o}, 0);
    wr(2'd2, 16'b01001); chk("R6", "no global enable", {31'd0, irq_o}, 0);
    wr(2'd2, 16'b11001); chk("R6", "all enables", {31'd0, irq_o}, 1);
    wr(2'd2, 16'b11010); chk("R6", "other channel enabled", {31'd0, irq_o}, 0);
    // R5 software write
    wr(2'd1, 16'h0);   chk("R5", "clear by write", {29'd0, flag_o}, 0);
    wr(2'd1, 16'h6);   chk("R5", "simulated interrupt", {29'd0, flag_o}, 32'h6);
    chk("R5", "irq from simulated flag", {31'd0, irq_o}, 1);
    wr(2'd1, 16'h0);
    // R8 hardware set beats simultaneous clear
    wr(2'd0, 16'o060);
    cmp_raw[1] = 1'b1;
    step(2);
    wr(2'd1, 16'h0);
    chk("R8", "set wins over clear", {29'd0, flag_o}, 32'h2);
    // R9 polarity change counts as transition
    wr(2'd1, 16'h0);
    wr(2'd0, 16'o200);
    step(3);
    wr(2'd0, 16'o300);
    chk("R9", "not yet set after polarity write", {29'd0, flag_o}, 0);
    rd(2'd3, r); chk("R2", "inverted status", {16'd0, r}, 32'h6);
    step(1);
    chk("R9", "set one edge after polarity write", {29'd0, flag_o}, 32'h4);
    // R11 status is read-only, cfg reads back
    wr(2'd3, 16'hFFFF);
    rd(2'd3, r); chk("R11", "status write ignored", {16'd0, r}, 32'h6);
    rd(2'd0, r); chk("R11", "cfg readback", {16'd0, r}, 32'o300);

    // random phase
    rd_addr = 2'd3;
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(3) == 0) cmp_raw = cmp_raw ^ 3'($urandom_range(7));
      if ($urandom_range(7) == 0) begin
        wr_en = 1'b1; wr_addr = 2'($urandom_range(3)); wr_data = 16'($urandom);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      if (c % 5 == 0) begin
        #0.5;
        chk("R2", "random status", {16'd0, rd_data}, {29'd0, m_s2 ^ pol_of(m_cfg)});
      end
    end
    wr_en = 1'b0;
    step(2);
    finish_run();
  end
endmodule